// File: doc/BRIEF.md
# Serial Rising Edge Pulse Generator

This block watches one serial input bit that is sampled on every rising clock edge. It raises a one-cycle pulse on its output each time the input moves from low to high. The input is assumed to change at most once per clock period, so it needs no synchroniser and no glitch filtering.

The block is a Moore machine with three states and a fixed two-bit encoding. The next-state bits come from two explicit equations, and the output is decoded from the registered state alone. Reset places the machine in a "seen high, no pulse" state. An input that is already high when reset is released therefore gives no pulse. The input must first be sampled low.

Top module: `rise_pulse_fsm`

## Requirements
- R1: An active-high synchronous reset puts the machine in the quiet-high state (code 00). Output `pulse_o` is 0 in the cycle after any clock edge at which `rst` is 1.
- R2: When `din` is sampled 0 at one clock edge and 1 at the next, `pulse_o` is 1 for the clock cycle that follows the second edge.
- R3: A pulse lasts exactly one cycle. If `din` stays high, `pulse_o` returns to 0 after the next edge.
- R4: If `din` is 1 at the first edge after reset is released, no pulse follows. A pulse needs an earlier low sample.
- R5: The state codes are: quiet-high = 00, low = 11, risen = 10. The output is `pulse_o = s[1] & ~s[0]`, so only code 10 drives it high.
- R6: Code 01 is unused. From 01, a sample of `din` = 0 leads to the low state (11), and a sample of `din` = 1 leads to the risen state (10), which gives a pulse. Code 01 itself drives `pulse_o` to 0.
- R7: Rising edges separated by a single low sample each produce their own pulse. For example, the pattern 0,1,0,1 gives two pulses.
- R8: A falling edge, a steady low input and a steady high input never produce a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial input bit |
| pulse_o | output | 1 | One-cycle pulse after a detected rising edge |

## Verification
A wrong state shows up at `pulse_o` no later than one clock edge after the input pattern that exposes it. Each possible error has its own sign:
- A state that forgets a low sample drops a pulse.
- A state that treats a high as a fresh low adds a pulse while the input is steady high.
- A wrong reset state gives a pulse right after reset.

The bench also forces the unused code into the state register and then drives both values of the input. This shows at the port that the machine always leaves code 01 after one edge.

// File: rtl/rise_pulse_pkg.sv
package rise_pulse_pkg;

    localparam int ST_W = 2;

    typedef logic [ST_W-1:0] st_t;

    localparam st_t ST_QUIET_HI = 2'b00;
    localparam st_t ST_LOW      = 2'b11;
    localparam st_t ST_RISEN    = 2'b10;
    localparam st_t ST_SPARE    = 2'b01;

    // next-state equations: d1 = ~x | y0, d0 = ~x
    function automatic st_t step_state(input st_t y, input logic x);
        st_t d;
        d[1] = ~x | y[0];
        d[0] = ~x;
        return d;
    endfunction

    function automatic logic decode_pulse(input st_t y);
        return y[1] & ~y[0];
    endfunction

endpackage

// File: rtl/rise_next_logic.sv
module rise_next_logic
    import rise_pulse_pkg::*;
(
    input  st_t  cur_s,
    input  logic x_in,
    output st_t  nxt_s
);
    always_comb begin
        nxt_s = step_state(cur_s, x_in);
    end
endmodule

// File: rtl/rise_out_decode.sv
module rise_out_decode
    import rise_pulse_pkg::*;
(
    input  st_t  cur_s,
    output logic pulse
);
    always_comb begin
        pulse = decode_pulse(cur_s);
    end
endmodule

// File: rtl/rise_pulse_fsm.sv
module rise_pulse_fsm
    import rise_pulse_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic pulse_o
);
    st_t state_q;
    st_t state_d;

    rise_next_logic u_next (
        .cur_s (state_q),
        .x_in  (din),
        .nxt_s (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_QUIET_HI;
        end else begin
            state_q <= state_d;
        end
    end

    rise_out_decode u_dec (
        .cur_s (state_q),
        .pulse (pulse_o)
    );

    // R1: reset lands in quiet-high with no pulse
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (state_q == ST_QUIET_HI && !pulse_o));

    // R2: low state followed by a high sample gives a pulse
    assert_rise_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOW && din) |=> pulse_o);

    // R3: a pulse never lasts two cycles
    assert_single_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);

    // R8: a low sample is never followed by a pulse
    assert_no_pulse_after_low_R8: assert property (@(posedge clk) disable iff (rst)
        !din |=> !pulse_o);

    // R6: the spare code is left after one edge
    assert_spare_exit_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SPARE) |=> (state_q != ST_SPARE));

    // R5: only the risen code drives the output
    always_comb begin
        assert_out_code_R5: assert (pulse_o == (state_q == ST_RISEN));
    end

endmodule

// File: tb/sim_rise_pulse_fsm.sv
`timescale 1ns/1ps
module sim_rise_pulse_fsm;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic pulse_o;

    int checks = 0;
    int errors = 0;
    bit prev_s = 1'b1;   // reference: last sampled input, reset counts as high
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    rise_pulse_fsm u0 (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .pulse_o (pulse_o)
    );

    task automatic check(input logic exp, input string req);
        checks++;
        if (pulse_o !== exp) begin
            errors++;
            $display("FAIL %s: pulse_o=%b expected=%b at %0t", req, pulse_o, exp, $time);
        end
    endtask

    // called at a falling edge; drives one sample and checks after the next rising edge
    task automatic step(input bit v, input string req);
        bit exp;
        din = v;
        @(negedge clk);
        exp = (!prev_s) && v;
        prev_s = v;
        check(exp, req);
    endtask

    task automatic do_reset(input bit x_during);
        rst = 1'b1;
        din = x_during;
        @(negedge clk);
        @(negedge clk);
        prev_s = 1'b1;
        check(1'b0, "R1");
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset(1'b0);

        // R4: high right after reset gives nothing
        step(1'b1, "R4");
        step(1'b1, "R8");
        // R2 and R3: a plain rise, then held high
        step(1'b0, "R8");
        step(1'b1, "R2");
        step(1'b1, "R3");
        step(1'b1, "R3");
        // R8: fall and steady low
        step(1'b0, "R8");
        step(1'b0, "R8");
        step(1'b0, "R8");
        // R7: back-to-back rises with one low cycle between
        step(1'b1, "R7");
        step(1'b0, "R7");
        step(1'b1, "R7");
        step(1'b0, "R7");
        step(1'b1, "R7");
        step(1'b0, "R7");

        // R1: reset with input low, then rise
        do_reset(1'b0);
        step(1'b0, "R8");
        step(1'b1, "R2");

        // R1: reset while a pulse is pending clears it
        step(1'b0, "R8");
        din = 1'b1;
        do_reset(1'b1);
        step(1'b1, "R4");

        // R6: spare code 01 with input high goes to risen (pulse)
        force u0.state_q = 2'b01;
        #0.1;
        check(1'b0, "R6");   // R5: code 01 drives no pulse
        release u0.state_q;
        prev_s = 1'b0;
        step(1'b1, "R6");
        step(1'b1, "R3");

        // R6: spare code 01 with input low goes to low, then rise pulses
        force u0.state_q = 2'b01;
        #0.1;
        check(1'b0, "R5");
        release u0.state_q;
        prev_s = 1'b0;
        step(1'b0, "R6");
        step(1'b1, "R6");

        // mixed pattern
        for (int i = 0; i < 40; i++) begin
            step(((i * 7 + 3) % 5) < 2, "R2");
        end

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule